// File: doc/BRIEF.md
# Impedance SAR Calibration Controller

This block tunes an output driver's impedance. It runs two binary searches in hardware, one after the other, against a single comparator input. The first search finds a 5-bit pull-up code and the second finds a 5-bit pull-down code. A one-cycle start request launches the whole sequence.

For each trial, the block drives a candidate code and the select line to the analog side. It then waits a settle window before it samples the comparator. Each search resolves the code from the most significant bit down.

When both codes are known, the block stores them in result registers and pulses an apply strobe, so that the pad logic adopts the new codes. It then drops its busy flag. The busy flag acts as the self-clearing "calibrate now" bit: software raises a start and sees busy fall when the work is done.

Top module: `imp_sar_cal`

## Requirements
- R1: After reset, busy, apply and comparator enable are 0, and both result outputs read 5'b10000.
- R2: A start seen while idle raises busy on the next clock edge. The pull-up search then runs first, with comparator enable at 1 and select at 1.
- R3: Each search begins with the trial code 5'b10000 and resolves bits 4 down to 0. A trial sets the bit under test and keeps every bit already decided.
- R4: In the pull-up search, a comparator value of 1 keeps the bit under test and 0 clears it. With a comparator that reads 1 exactly when the trial code is at most T, the pull-up result equals T.
- R5: The pull-down search runs second, with select at 0. A comparator value of 1 clears the bit under test and 0 keeps it. With a comparator that reads 1 exactly when the trial code exceeds T, the pull-down result equals T.
- R6: Comparator enable is 0 for one cycle between the two searches, and again in the apply cycle. The pull-up result is already stored before the pull-down search begins.
- R7: After both results are stored, apply is high for exactly one cycle. Busy falls on the following edge, so busy is high for 10*L+2 cycles.
- R8: Each trial code is held for L = max(settle_i, 4) cycles before the comparator is sampled. settle_i is read only when a sequence starts.
- R9: A start that arrives while busy has no effect: the run length, the results and the single apply pulse are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Calibration request, one cycle |
| settle_i | input | 8 | Settle cycles per trial (values below 4 act as 4) |
| cmp_i | input | 1 | Comparator result |
| cmp_en_o | output | 1 | Comparator enable |
| pu_sel_o | output | 1 | 1 selects the pull-up leg, 0 the pull-down leg |
| pu_code_o | output | 5 | Pull-up trial code during that search, otherwise the stored result |
| pd_code_o | output | 5 | Pull-down trial code during that search, otherwise the stored result |
| pu_res_o | output | 5 | Stored pull-up result |
| pd_res_o | output | 5 | Stored pull-down result |
| apply_o | output | 1 | One-cycle strobe that applies the new codes |
| busy_o | output | 1 | High from start until the cycle after apply |

## Verification
Every pair of pull-up and pull-down thresholds, 0 to 31 each, is run against a monotonic comparator model. A wrong keep or clear polarity in either search, or a skipped bit, shows up as a wrong result for some threshold. The extreme thresholds 0 and 31 separate a bad MSB seed from a bad LSB step.

Runs with settle values 0, 3, 4, 6 and 9 separate the clamp from the raw count through the measured busy length. A settle change made in the middle of a run shows whether the value is latched at start. A start injected mid-run must leave the length, the results and the apply count unchanged.

// File: rtl/imp_cal_pkg.sv
package imp_cal_pkg;
    localparam int CAL_CODE_W    = 5;
    localparam int CAL_IDX_W     = $clog2(CAL_CODE_W);
    localparam int CAL_CNT_W     = 8;
    localparam int CAL_MIN_SETTLE = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SRCH  = 2'd1,
        ST_GAP   = 2'd2,
        ST_APPLY = 2'd3
    } cal_st_e;

    typedef struct packed {
        cal_st_e               st;
        logic                  pd_phase;
        logic [CAL_IDX_W-1:0]  idx;
        logic [CAL_CODE_W-1:0] trial;
        logic [CAL_CNT_W-1:0]  tmr;
        logic [CAL_CNT_W-1:0]  lim;
        logic [CAL_CODE_W-1:0] pu_res;
        logic [CAL_CODE_W-1:0] pd_res;
    } cal_regs_t;
endpackage

// File: rtl/imp_settle_clamp.sv
module imp_settle_clamp #(
    parameter int CNT_W = 8,
    parameter int MIN_CYC = 4
) (
    input  logic [CNT_W-1:0] req_i,
    output logic [CNT_W-1:0] lim_o
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_CYC);

    always_comb begin
        lim_o = (req_i < MIN_V) ? MIN_V : req_i;
    end
endmodule

// File: rtl/imp_settle_timer.sv
module imp_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] tmr_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             expire_o,
    output logic [CNT_W-1:0] tmr_inc_o
);
    always_comb begin
        expire_o  = (tmr_i == (lim_i - 1'b1));
        tmr_inc_o = tmr_i + 1'b1;
    end
endmodule

// File: rtl/imp_sar_bit.sv
module imp_sar_bit #(
    parameter int CODE_W = 5,
    parameter int IDX_W  = 3,
    parameter bit INVERT = 1'b0
) (
    input  logic [CODE_W-1:0] trial_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              cmp_i,
    output logic [CODE_W-1:0] decided_o,
    output logic [CODE_W-1:0] next_o
);
    logic keep;

    always_comb begin
        keep      = cmp_i ^ INVERT;
        decided_o = trial_i;
        if (!keep) begin
            decided_o[idx_i] = 1'b0;
        end
        next_o = decided_o;
        if (idx_i != '0) begin
            next_o[idx_i - 1'b1] = 1'b1;
        end
    end
endmodule

// File: rtl/imp_sar_cal.sv
module imp_sar_cal
    import imp_cal_pkg::*;
#(
    parameter int CODE_W     = CAL_CODE_W,
    parameter int CNT_W      = CAL_CNT_W,
    parameter int MIN_SETTLE = CAL_MIN_SETTLE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  settle_i,
    input  logic              cmp_i,
    output logic              cmp_en_o,
    output logic              pu_sel_o,
    output logic [CODE_W-1:0] pu_code_o,
    output logic [CODE_W-1:0] pd_code_o,
    output logic [CODE_W-1:0] pu_res_o,
    output logic [CODE_W-1:0] pd_res_o,
    output logic              apply_o,
    output logic              busy_o
);
    localparam int IDX_W = CAL_IDX_W;
    localparam logic [CODE_W-1:0] MSB_ONE = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [IDX_W-1:0]  TOP_IDX = IDX_W'(CODE_W - 1);

    cal_regs_t r_q, r_d;

    logic [CNT_W-1:0]  lim_start;
    logic              expire;
    logic [CNT_W-1:0]  tmr_inc;
    logic [CODE_W-1:0] dec_v [2];
    logic [CODE_W-1:0] nxt_v [2];
    logic [CODE_W-1:0] dec_sel, nxt_sel;

    imp_settle_clamp #(.CNT_W(CNT_W), .MIN_CYC(MIN_SETTLE)) u_clamp (
        .req_i (settle_i),
        .lim_o (lim_start)
    );

    imp_settle_timer #(.CNT_W(CNT_W)) u_timer (
        .tmr_i     (r_q.tmr),
        .lim_i     (r_q.lim),
        .expire_o  (expire),
        .tmr_inc_o (tmr_inc)
    );

    // index 0: pull-up polarity, index 1: pull-down (inverted) polarity
    for (genvar g = 0; g < 2; g++) begin : g_pol
        imp_sar_bit #(
            .CODE_W (CODE_W),
            .IDX_W  (IDX_W),
            .INVERT (g[0])
        ) u_bit (
            .trial_i   (r_q.trial),
            .idx_i     (r_q.idx),
            .cmp_i     (cmp_i),
            .decided_o (dec_v[g]),
            .next_o    (nxt_v[g])
        );
    end

    always_comb begin
        dec_sel = r_q.pd_phase ? dec_v[1] : dec_v[0];
        nxt_sel = r_q.pd_phase ? nxt_v[1] : nxt_v[0];
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st       = ST_SRCH;
                    r_d.pd_phase = 1'b0;
                    r_d.idx      = TOP_IDX;
                    r_d.trial    = MSB_ONE;
                    r_d.tmr      = '0;
                    r_d.lim      = lim_start;
                end
            end
            ST_SRCH: begin
                if (!expire) begin
                    r_d.tmr = tmr_inc;
                end else if (r_q.idx != '0) begin
                    r_d.trial = nxt_sel;
                    r_d.idx   = r_q.idx - 1'b1;
                    r_d.tmr   = '0;
                end else if (!r_q.pd_phase) begin
                    r_d.pu_res = dec_sel;
                    r_d.trial  = dec_sel;
                    r_d.st     = ST_GAP;
                end else begin
                    r_d.pd_res = dec_sel;
                    r_d.trial  = dec_sel;
                    r_d.st     = ST_APPLY;
                end
            end
            ST_GAP: begin
                r_d.st       = ST_SRCH;
                r_d.pd_phase = 1'b1;
                r_d.idx      = TOP_IDX;
                r_d.trial    = MSB_ONE;
                r_d.tmr      = '0;
            end
            ST_APPLY: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.pd_phase <= 1'b0;
            r_q.idx      <= TOP_IDX;
            r_q.trial    <= MSB_ONE;
            r_q.tmr      <= '0;
            r_q.lim      <= CNT_W'(MIN_SETTLE);
            r_q.pu_res   <= MSB_ONE;
            r_q.pd_res   <= MSB_ONE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy_o    = (r_q.st != ST_IDLE);
        cmp_en_o  = (r_q.st == ST_SRCH);
        apply_o   = (r_q.st == ST_APPLY);
        pu_sel_o  = !r_q.pd_phase;
        pu_res_o  = r_q.pu_res;
        pd_res_o  = r_q.pd_res;
        pu_code_o = (cmp_en_o && !r_q.pd_phase) ? r_q.trial : r_q.pu_res;
        pd_code_o = (cmp_en_o &&  r_q.pd_phase) ? r_q.trial : r_q.pd_res;
    end
endmodule

// File: rtl/imp_sar_cal_chk.sv
module imp_sar_cal_chk #(
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              apply_o,
    input logic              cmp_en_o,
    input logic              pu_sel_o,
    input logic [CODE_W-1:0] pu_code_o,
    input logic [CODE_W-1:0] pd_code_o
);
    localparam logic [CODE_W-1:0] MSB_ONE = {1'b1, {(CODE_W-1){1'b0}}};

    // R7
    apply_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apply_o |=> (!apply_o && !busy_o));

    // R6
    apply_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apply_o |-> (busy_o && !cmp_en_o));

    // R2
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R3
    first_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_en_o) |-> (pu_sel_o ? (pu_code_o == MSB_ONE) : (pd_code_o == MSB_ONE)));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !apply_o) |=> busy_o);

    // R2
    cmp_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en_o |-> busy_o);
endmodule

bind imp_sar_cal imp_sar_cal_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .apply_o   (apply_o),
    .cmp_en_o  (cmp_en_o),
    .pu_sel_o  (pu_sel_o),
    .pu_code_o (pu_code_o),
    .pd_code_o (pd_code_o)
);

// File: tb/imp_sar_cal_test.sv
`timescale 1ns/1ps
module imp_sar_cal_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] settle_i = 8'd4;
    logic       cmp_i;
    logic       cmp_en_o, pu_sel_o, apply_o, busy_o;
    logic [4:0] pu_code_o, pd_code_o, pu_res_o, pd_res_o;

    int total = 0;
    int bad = 0;
    int t_pu = 0;
    int t_pd = 0;

    always #10 clk = ~clk;

    imp_sar_cal uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .settle_i  (settle_i),
        .cmp_i     (cmp_i),
        .cmp_en_o  (cmp_en_o),
        .pu_sel_o  (pu_sel_o),
        .pu_code_o (pu_code_o),
        .pd_code_o (pd_code_o),
        .pu_res_o  (pu_res_o),
        .pd_res_o  (pd_res_o),
        .apply_o   (apply_o),
        .busy_o    (busy_o)
    );

    // behavioural analog model: monotonic comparators around the targets
    assign cmp_i = !cmp_en_o ? 1'b0 :
                   pu_sel_o ? (int'(pu_code_o) <= t_pu) : (int'(pd_code_o) > t_pd);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (pu=%0d pd=%0d)", req, act, exp, t_pu, t_pd);
        end
    endtask

    task automatic run(input int tpu, input int tpd, input int settle,
                       input bit inject, input bit change_settle);
        int len = 0;
        int gaps = 0;
        int applies = 0;
        int rises = 0;
        int lim;
        bit prev_en = 1'b0;
        t_pu = tpu;
        t_pd = tpd;
        settle_i = 8'(settle);
        lim = (settle < 4) ? 4 : settle;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R2: busy rises on the edge that samples start
        chk(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
        chk(cmp_en_o && pu_sel_o, "R2 pull-up first", int'(pu_sel_o), 1);
        while (busy_o && len < 4000) begin
            len++;
            if (inject && len == 7) start_i = 1'b1;
            if (inject && len == 8) start_i = 1'b0;
            if (change_settle && len == 3) settle_i = 8'd20;
            if (!cmp_en_o) gaps++;
            if (cmp_en_o && !prev_en) begin
                rises++;
                // R3: each search seeds 10000; R5: second search uses select 0
                if (rises == 1)
                    chk(pu_sel_o && pu_code_o == 5'b10000, "R3 pu seed", int'(pu_code_o), 16);
                else begin
                    chk(!pu_sel_o && pd_code_o == 5'b10000, "R3/R5 pd seed", int'(pd_code_o), 16);
                    // R6: pull-up result stored before pull-down search
                    chk(int'(pu_res_o) == tpu, "R6 pu stored early", int'(pu_res_o), tpu);
                end
            end
            if (apply_o) begin
                applies++;
                chk(int'(pu_res_o) == tpu, "R4 pu result", int'(pu_res_o), tpu);
                chk(int'(pd_res_o) == tpd, "R5 pd result", int'(pd_res_o), tpd);
            end
            prev_en = cmp_en_o;
            @(negedge clk);
        end
        start_i = 1'b0;
        if (len >= 4000) chk(1'b0, "watchdog", len, 10 * lim + 2);
        // R7/R8/R9: busy length, single apply, two quiet cycles
        chk(len == 10 * lim + 2, "R8 busy length", len, 10 * lim + 2);
        chk(applies == 1, "R7 apply count", applies, 1);
        chk(gaps == 2, "R6 enable gaps", gaps, 2);
        settle_i = 8'd4;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(!busy_o && !apply_o && !cmp_en_o, "R1 reset flags", int'(busy_o), 0);
        chk(pu_res_o == 5'b10000, "R1 pu reset", int'(pu_res_o), 16);
        chk(pd_res_o == 5'b10000, "R1 pd reset", int'(pd_res_o), 16);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && pu_res_o == 5'b10000, "R1 after release", int'(busy_o), 0);
        // R4/R5: exhaustive threshold sweep
        for (int a = 0; a < 32; a++)
            for (int b = 0; b < 32; b++)
                run(a, b, 4, 1'b0, 1'b0);
        // R8: settle clamp and longer windows
        run(0, 31, 0, 1'b0, 1'b0);
        run(31, 0, 3, 1'b0, 1'b0);
        run(17, 9, 6, 1'b0, 1'b0);
        run(5, 26, 9, 1'b0, 1'b0);
        // R8: settle latched at start
        run(12, 20, 5, 1'b0, 1'b1);
        // R9: start while busy ignored
        run(21, 10, 4, 1'b1, 1'b0);
        run(3, 30, 7, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk(!busy_o && !apply_o, "R9 idle after", int'(busy_o), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 190000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule